// File: doc/BRIEF.md
# Master/Filler Mode Switch Controller

This block controls a core that normally runs one latency-sensitive master thread out of order. When the master thread reports a stall, the block first requires the stall to be long enough to be worth filling. It then moves the core into a multi-threaded in-order filler mode. During filler mode the master's architectural registers, which sit in the low region of the physical register file, are protected from every write. The upper part of that file is divided into fixed windows, one per filler thread. Instruction and data cache requests are steered away from the local L1 and sent to a small L0 cache that forwards to the partner core's L1. Predictor and TLB copies are switched so that filler threads never update the master's copies.

When the master stall clears, the controller stops filler issue and waits for in-flight filler work to reach zero. It then hands the core back to the master thread, which takes one cycle when nothing is still in flight. The block only produces control signals. Cache arrays, the pipeline and the register file contents are outside it.

Top module: `dyad_mode_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `state_o` is 0 (master), `mode_fill` and `pred_sel` are 0, `master_issue_en` is 1 and `filler_issue_en` is 0.
- R2: In master state, `master_stall` must be sampled high on `stall_thresh`+1 consecutive rising edges before the state leaves master, and it leaves on that edge. A run of `stall_thresh` or fewer high samples never causes a switch, and a low sample restarts the count.
- R3: `state_o` codes are: 0 master, 1 enter-fill, 2 fill, 3 drain. Enter-fill lasts exactly one cycle and is always followed by fill.
- R4: Fill is held while `master_stall` is high. The first edge at which `master_stall` is sampled low moves the state to drain.
- R5: Drain is held while `filler_inflight` is non-zero. The first edge at which it is sampled as zero moves the state to master.
- R6: `mode_fill` is 1 in enter-fill, fill and drain, and 0 in master. `master_issue_en` is 1 only in master, and `filler_issue_en` is 1 only in fill.
- R7: `pred_sel` (predictor/TLB copy select, 1 = filler copy) equals `mode_fill` in every cycle and changes on the same edge.
- R8: For each write port p, `rf_wr_en_out[p]` equals `rf_wr_en_in[p]`, except that it is forced to 0 when `mode_fill` is 1 and the port's 7-bit address (bits p*7 to p*7+6 of `rf_wr_addr_in`) is below ARCH_REGS (32). This is combinational.
- R9: `ic_req` and `dc_req` are forwarded to `*_local_req` when `mode_fill` is 0 and to `*_remote_req` when it is 1. This is combinational, and a request never appears on both outputs.
- R10: The filler register map gives `fill_preg` = 32 × (`fill_tid`+1) + `fill_areg` with `fill_map_ok` = 1 when `fill_tid` < 3. For `fill_tid` = 3 it gives `fill_map_ok` = 0 and `fill_preg` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_thresh | input | 16 | Number of stall samples that are tolerated before a switch |
| master_stall | input | 1 | Master thread is waiting on a long-latency event |
| filler_inflight | input | 6 | Count of filler operations still in flight |
| rf_wr_en_in | input | 2 | Register file write enables from the pipeline |
| rf_wr_addr_in | input | 14 | Packed physical write addresses, 7 bits per port |
| ic_req | input | 1 | Instruction fetch request |
| dc_req | input | 1 | Data access request |
| fill_tid | input | 2 | Filler thread id to map |
| fill_areg | input | 5 | Filler architectural register to map |
| state_o | output | 2 | Controller state code |
| mode_fill | output | 1 | Core is in multi-thread in-order mode |
| pred_sel | output | 1 | Selects the filler copy of the predictors and TLBs |
| master_issue_en | output | 1 | Master thread may issue |
| filler_issue_en | output | 1 | Filler threads may issue |
| rf_wr_en_out | output | 2 | Gated register file write enables |
| ic_local_req | output | 1 | Fetch request to the local L1 |
| ic_remote_req | output | 1 | Fetch request to the L0/partner L1 |
| dc_local_req | output | 1 | Data request to the local L1 |
| dc_remote_req | output | 1 | Data request to the L0/partner L1 |
| fill_preg | output | 7 | Physical register for the filler register |
| fill_map_ok | output | 1 | Filler thread id is within range |

## Verification
The state, `mode_fill`, `pred_sel` and the issue enables are registered. They are due one rising edge after the inputs that cause them, so the bench drives inputs at the falling edge and reads these outputs 1 ns after the next rising edge. Write gating, request steering and the register map are combinational on the current inputs and the current mode. They are read 1 ns after the inputs change and before the next rising edge. A stall switch is due on the (`stall_thresh`+1)-th consecutive high sample. The bench's reference model advances once per edge on the same sampled values, so every comparison lines up with that edge count.

// File: rtl/dyad_pkg.sv
// Shared types for the master/filler mode controller.
package dyad_pkg;
    typedef enum logic [1:0] {
        ST_MASTER = 2'd0,
        ST_ENTER  = 2'd1,
        ST_FILL   = 2'd2,
        ST_DRAIN  = 2'd3
    } dyad_state_e;
endpackage

// File: rtl/stall_qual.sv
// Counts consecutive stall samples while the core is in master state.
// Assumes: stall level is synchronous; the counter saturates at all-ones.
module stall_qual #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_master,
    input  logic             master_stall,
    input  logic [CNT_W-1:0] thresh,
    output logic             long_stall
);
    logic [CNT_W-1:0] run_q;

    // Track how many earlier edges saw the stall in master state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (in_master && master_stall) begin
            if (run_q != {CNT_W{1'b1}}) begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    // Stall qualifies once the earlier run reaches the threshold.
    always_comb begin
        long_stall = in_master && master_stall && (run_q >= thresh);
    end
endmodule

// File: rtl/mode_fsm.sv
// Four-state mode sequencer: master, enter-fill, fill, drain.
// Assumes: long_stall is valid only in master state.
module mode_fsm
    import dyad_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        long_stall,
    input  logic        master_stall,
    input  logic        inflight_zero,
    output dyad_state_e state_q,
    output dyad_state_e state_d,
    output logic        mode_fill_q,
    output logic        master_iss_q,
    output logic        filler_iss_q
);
    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MASTER: if (long_stall)    state_d = ST_ENTER;
            ST_ENTER:                     state_d = ST_FILL;
            ST_FILL:   if (!master_stall) state_d = ST_DRAIN;
            ST_DRAIN:  if (inflight_zero) state_d = ST_MASTER;
            default:                      state_d = ST_MASTER;
        endcase
    end

    // State and registered mode/issue flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_MASTER;
            mode_fill_q  <= 1'b0;
            master_iss_q <= 1'b1;
            filler_iss_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            mode_fill_q  <= (state_d != ST_MASTER);
            master_iss_q <= (state_d == ST_MASTER);
            filler_iss_q <= (state_d == ST_FILL);
        end
    end
endmodule

// File: rtl/reg_partition.sv
// Register file partition: protects the master region outside master mode
// and maps filler (thread, arch reg) pairs into upper windows.
// Assumes: master architectural state occupies the lowest ARCH_REGS entries.
module reg_partition #(
    parameter int PHYS_REGS = 128,
    parameter int ARCH_REGS = 32,
    parameter int NWP       = 2,
    parameter int PAW       = $clog2(PHYS_REGS),
    parameter int AW        = $clog2(ARCH_REGS),
    parameter int SLOTS     = (PHYS_REGS - ARCH_REGS) / ARCH_REGS,
    parameter int TIDW      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               mode_fill,
    input  logic [NWP-1:0]     wr_en_in,
    input  logic [NWP*PAW-1:0] wr_addr_in,
    input  logic [TIDW-1:0]    tid,
    input  logic [AW-1:0]      areg,
    output logic [NWP-1:0]     wr_en_out,
    output logic [PAW-1:0]     preg,
    output logic               map_ok
);
    // One gate per write port.
    for (genvar p = 0; p < NWP; p++) begin : g_port
        logic in_master_region;
        // Detect a write aimed at the protected master region.
        always_comb begin
            in_master_region = wr_addr_in[p*PAW +: PAW] < PAW'(ARCH_REGS);
            wr_en_out[p]     = wr_en_in[p] && !(mode_fill && in_master_region);
        end
    end

    // Filler window lookup.
    always_comb begin
        map_ok = (32'(tid) < SLOTS);
        preg   = map_ok ? PAW'(ARCH_REGS * (32'(tid) + 1) + 32'(areg)) : '0;
    end
endmodule

// File: rtl/access_steer.sv
// Routes cache requests to the local L1 or to the L0/partner path, and
// holds the predictor/TLB copy select.
// Assumes: sel_d is the next-cycle filler mode from the sequencer.
module access_steer #(
    parameter int NPORT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_d,
    input  logic             mode_fill,
    input  logic [NPORT-1:0] req_in,
    output logic [NPORT-1:0] local_req,
    output logic [NPORT-1:0] remote_req,
    output logic             pred_sel
);
    // Predictor/TLB copy select register, loaded with the mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_sel <= 1'b0;
        end else begin
            pred_sel <= sel_d;
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_req
        // Send each request to exactly one destination.
        always_comb begin
            local_req[i]  = req_in[i] && !mode_fill;
            remote_req[i] = req_in[i] &&  mode_fill;
        end
    end
endmodule

// File: rtl/dyad_mode_ctrl.sv
// Top of the master/filler mode controller. Qualifies master stalls,
// sequences the mode, gates register writes and steers cache requests.
// Assumes: all inputs are synchronous to clk.
module dyad_mode_ctrl
    import dyad_pkg::*;
#(
    parameter int PHYS_REGS = 128,
    parameter int ARCH_REGS = 32,
    parameter int NWP       = 2,
    parameter int CNT_W     = 16,
    parameter int INFL_W    = 6,
    localparam int PAW      = $clog2(PHYS_REGS),
    localparam int AW       = $clog2(ARCH_REGS),
    localparam int SLOTS    = (PHYS_REGS - ARCH_REGS) / ARCH_REGS,
    localparam int TIDW     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   stall_thresh,
    input  logic               master_stall,
    input  logic [INFL_W-1:0]  filler_inflight,
    input  logic [NWP-1:0]     rf_wr_en_in,
    input  logic [NWP*PAW-1:0] rf_wr_addr_in,
    input  logic               ic_req,
    input  logic               dc_req,
    input  logic [TIDW-1:0]    fill_tid,
    input  logic [AW-1:0]      fill_areg,
    output logic [1:0]         state_o,
    output logic               mode_fill,
    output logic               pred_sel,
    output logic               master_issue_en,
    output logic               filler_issue_en,
    output logic [NWP-1:0]     rf_wr_en_out,
    output logic               ic_local_req,
    output logic               ic_remote_req,
    output logic               dc_local_req,
    output logic               dc_remote_req,
    output logic [PAW-1:0]     fill_preg,
    output logic               fill_map_ok
);
    dyad_state_e state_q;
    dyad_state_e state_d;
    logic        long_stall;
    logic        inflight_zero;
    logic [1:0]  req_vec;
    logic [1:0]  loc_vec;
    logic [1:0]  rem_vec;

    // Glue: drain condition, request packing and state export.
    always_comb begin
        inflight_zero = (filler_inflight == '0);
        req_vec       = {dc_req, ic_req};
        ic_local_req  = loc_vec[0];
        dc_local_req  = loc_vec[1];
        ic_remote_req = rem_vec[0];
        dc_remote_req = rem_vec[1];
        state_o       = state_q;
    end

    stall_qual #(.CNT_W(CNT_W)) u_qual (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_master    (state_q == ST_MASTER),
        .master_stall (master_stall),
        .thresh       (stall_thresh),
        .long_stall   (long_stall)
    );

    mode_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .long_stall    (long_stall),
        .master_stall  (master_stall),
        .inflight_zero (inflight_zero),
        .state_q       (state_q),
        .state_d       (state_d),
        .mode_fill_q   (mode_fill),
        .master_iss_q  (master_issue_en),
        .filler_iss_q  (filler_issue_en)
    );

    reg_partition #(
        .PHYS_REGS (PHYS_REGS),
        .ARCH_REGS (ARCH_REGS),
        .NWP       (NWP)
    ) u_part (
        .mode_fill  (mode_fill),
        .wr_en_in   (rf_wr_en_in),
        .wr_addr_in (rf_wr_addr_in),
        .tid        (fill_tid),
        .areg       (fill_areg),
        .wr_en_out  (rf_wr_en_out),
        .preg       (fill_preg),
        .map_ok     (fill_map_ok)
    );

    access_steer #(.NPORT(2)) u_steer (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_d      (state_d != ST_MASTER),
        .mode_fill  (mode_fill),
        .req_in     (req_vec),
        .local_req  (loc_vec),
        .remote_req (rem_vec),
        .pred_sel   (pred_sel)
    );
endmodule

// File: rtl/dyad_mode_ctrl_chk.sv
// Property checker for dyad_mode_ctrl, attached by bind.
module dyad_mode_ctrl_chk #(
    parameter int NWP       = 2,
    parameter int PAW       = 7,
    parameter int ARCH_REGS = 32,
    parameter int INFL_W    = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               master_stall,
    input logic [INFL_W-1:0]  filler_inflight,
    input logic [NWP-1:0]     rf_wr_en_out,
    input logic [NWP*PAW-1:0] rf_wr_addr_in,
    input logic [1:0]         state_o,
    input logic               mode_fill,
    input logic               pred_sel,
    input logic               master_issue_en,
    input logic               filler_issue_en,
    input logic               ic_local_req,
    input logic               ic_remote_req,
    input logic               dc_local_req,
    input logic               dc_remote_req
);
    // R3: enter-fill always moves on to fill.
    p_enter_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd1 |=> state_o == 2'd2);

    // R2: without a stall the master state is kept.
    p_no_stall_stay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && !master_stall) |=> state_o == 2'd0);

    // R4: stall release leaves fill for drain.
    p_fill_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && !master_stall) |=> state_o == 2'd3);

    // R5: drain waits for in-flight work.
    p_drain_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3 && filler_inflight != '0) |=> state_o == 2'd3);

    // R6: issue enables are exclusive and follow the state.
    p_issue_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({master_issue_en, filler_issue_en}) <= 1 &&
        (master_issue_en == (state_o == 2'd0)));

    // R7: copy select tracks the mode register.
    p_pred_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pred_sel == mode_fill);

    // R9: a request goes to one destination at most.
    p_one_route_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ic_local_req, ic_remote_req}) &&
        $onehot0({dc_local_req, dc_remote_req}));

    // R8: no write to the master region outside master mode.
    for (genvar p = 0; p < NWP; p++) begin : g_wr
        p_master_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_fill && rf_wr_addr_in[p*PAW +: PAW] < PAW'(ARCH_REGS))
                |-> !rf_wr_en_out[p]);
    end
endmodule

bind dyad_mode_ctrl dyad_mode_ctrl_chk #(
    .NWP       (NWP),
    .PAW       (PAW),
    .ARCH_REGS (ARCH_REGS),
    .INFL_W    (INFL_W)
) u_chk (.*);

// File: tb/dyad_mode_ctrl_tb.sv
module dyad_mode_ctrl_tb;
    localparam int PAW   = 7;
    localparam int AW    = 5;
    localparam int TIDW  = 2;
    localparam int NWP   = 2;
    localparam int CNT_W = 16;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [CNT_W-1:0]   stall_thresh;
    logic               master_stall;
    logic [5:0]         filler_inflight;
    logic [NWP-1:0]     rf_wr_en_in;
    logic [NWP*PAW-1:0] rf_wr_addr_in;
    logic               ic_req, dc_req;
    logic [TIDW-1:0]    fill_tid;
    logic [AW-1:0]      fill_areg;
    logic [1:0]         state_o;
    logic               mode_fill, pred_sel, master_issue_en, filler_issue_en;
    logic [NWP-1:0]     rf_wr_en_out;
    logic               ic_local_req, ic_remote_req, dc_local_req, dc_remote_req;
    logic [PAW-1:0]     fill_preg;
    logic               fill_map_ok;

    int total = 0;
    int bad   = 0;
    logic [1:0]       m_state;
    logic [CNT_W-1:0] m_cnt;

    always #5 clk = ~clk;

    dyad_mode_ctrl u_dut (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_wr(input logic en, input logic [PAW-1:0] a, input logic fill);
        return en && !(fill && a < 7'd32);
    endfunction

    function automatic logic [PAW-1:0] exp_preg(input logic [TIDW-1:0] t, input logic [AW-1:0] r);
        return (t < 2'd3) ? PAW'(32 * (int'(t) + 1) + int'(r)) : '0;
    endfunction

    // Reference model step on the values sampled at an edge.
    task automatic model_step();
        logic [1:0] nxt;
        nxt = m_state;
        case (m_state)
            2'd0: if (master_stall && m_cnt >= stall_thresh) nxt = 2'd1;
            2'd1: nxt = 2'd2;
            2'd2: if (!master_stall) nxt = 2'd3;
            default: if (filler_inflight == 0) nxt = 2'd0;
        endcase
        if (m_state == 2'd0 && master_stall)
            m_cnt = (m_cnt == '1) ? m_cnt : m_cnt + 1'b1;
        else
            m_cnt = '0;
        m_state = nxt;
    endtask

    task automatic check_regs();
        chk("R3 state", 32'(state_o), 32'(m_state));
        chk("R6 mode_fill", 32'(mode_fill), 32'(m_state != 2'd0));
        chk("R6 master_issue", 32'(master_issue_en), 32'(m_state == 2'd0));
        chk("R6 filler_issue", 32'(filler_issue_en), 32'(m_state == 2'd2));
        chk("R7 pred_sel", 32'(pred_sel), 32'(m_state != 2'd0));
    endtask

    task automatic check_comb();
        logic f;
        f = (m_state != 2'd0);
        for (int p = 0; p < NWP; p++)
            chk("R8 wr_en", 32'(rf_wr_en_out[p]),
                32'(exp_wr(rf_wr_en_in[p], rf_wr_addr_in[p*PAW +: PAW], f)));
        chk("R9 ic_local", 32'(ic_local_req), 32'(ic_req && !f));
        chk("R9 ic_remote", 32'(ic_remote_req), 32'(ic_req && f));
        chk("R9 dc_local", 32'(dc_local_req), 32'(dc_req && !f));
        chk("R9 dc_remote", 32'(dc_remote_req), 32'(dc_req && f));
        chk("R10 preg", 32'(fill_preg), 32'(exp_preg(fill_tid, fill_areg)));
        chk("R10 ok", 32'(fill_map_ok), 32'(fill_tid < 2'd3));
    endtask

    task automatic tick(input logic st, input logic [5:0] inf);
        @(negedge clk);
        master_stall    = st;
        filler_inflight = inf;
        rf_wr_en_in     = NWP'($urandom);
        rf_wr_addr_in   = (NWP*PAW)'($urandom);
        ic_req          = 1'($urandom);
        dc_req          = 1'($urandom);
        fill_tid        = TIDW'($urandom);
        fill_areg       = AW'($urandom);
        #1 check_comb();
        @(posedge clk);
        model_step();
        #1 check_regs();
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int burst;
        logic st;
        void'($urandom(32'd4242));
        rst_n = 1'b0; stall_thresh = 16'd3; master_stall = 1'b0; filler_inflight = '0;
        rf_wr_en_in = '0; rf_wr_addr_in = '0; ic_req = 1'b0; dc_req = 1'b0;
        fill_tid = '0; fill_areg = '0;
        m_state = 2'd0; m_cnt = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 state", 32'(state_o), 32'd0);
        chk("R1 mode_fill", 32'(mode_fill), 32'd0);
        chk("R1 pred_sel", 32'(pred_sel), 32'd0);
        chk("R1 master_issue", 32'(master_issue_en), 32'd1);
        chk("R1 filler_issue", 32'(filler_issue_en), 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R2: three samples at threshold 3 do not switch.
        repeat (3) tick(1'b1, 6'd0);
        tick(1'b0, 6'd0);
        chk("R2 short stall", 32'(state_o), 32'd0);
        // R2: the fourth consecutive sample switches.
        repeat (3) tick(1'b1, 6'd0);
        chk("R2 before edge", 32'(state_o), 32'd0);
        tick(1'b1, 6'd0);
        chk("R2 switch", 32'(state_o), 32'd1);
        tick(1'b1, 6'd2);
        chk("R3 to fill", 32'(state_o), 32'd2);
        tick(1'b1, 6'd2);
        chk("R4 hold fill", 32'(state_o), 32'd2);
        tick(1'b0, 6'd2);
        chk("R4 to drain", 32'(state_o), 32'd3);
        tick(1'b0, 6'd1);
        chk("R5 hold drain", 32'(state_o), 32'd3);
        tick(1'b0, 6'd0);
        chk("R5 to master", 32'(state_o), 32'd0);
        // R2: zero threshold switches on the first sample.
        stall_thresh = 16'd0;
        tick(1'b1, 6'd0);
        chk("R2 zero thresh", 32'(state_o), 32'd1);
        tick(1'b0, 6'd0);
        tick(1'b0, 6'd0);
        tick(1'b0, 6'd0);
        chk("R5 fast resume", 32'(state_o), 32'd0);

        // Random bursts of stalls with varying thresholds.
        burst = 0; st = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (i % 500 == 0) stall_thresh = CNT_W'($urandom_range(0, 6));
            if (burst == 0) begin
                st = ~st;
                burst = $urandom_range(1, 10);
            end
            burst--;
            tick(st, ($urandom_range(0, 3) == 0) ? 6'd0 : 6'($urandom_range(1, 40)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule